// File: doc/BRIEF.md
# Mode-Selectable Parallel-to-Serial Line Transmitter

This block turns parallel words into one bit-serial line stream. A word enters on a word-rate retiming clock. It then crosses into the bit-clock domain at a word boundary and is shifted out one bit per bit clock, with the most significant bit first. A divider inside the block counts bit clocks. From that count it makes the load strobe for the shift register and a sub-rate clock output at word rate, which the system can return as the retiming clock.

Two mode pins choose the format. The rate select picks high-rate operation when low and low-rate operation when high. The width select matters only at the low rate, where it picks nibble words when high and byte words when low. Because of this, pins left at their pulled-up level give low-rate nibble operation. In nibble format only the upper four data inputs are sent. An active-low select switches the bit clock from the internal source to an external one. An active-low asynchronous reset clears the divider and disables the line outputs.

Top module: `par2ser_tx`

## Requirements
- R1: With rate_sel_i low, the word is sent as 8 bits, data_i[7] first and data_i[0] last.
- R2: With rate_sel_i high and nib_sel_i low, the word is sent as 8 bits, data_i[7] first.
- R3: With rate_sel_i high and nib_sel_i high, the word is sent as 4 bits, data_i[7] down to data_i[4]. data_i[3:0] has no effect on the line.
- R4: While rate_sel_i is low, nib_sel_i has no effect and the format stays byte.
- R5: Each word occupies exactly 8 bit clocks in byte format or 4 in nibble format. sub_clk_o rises in the bit period that carries the first bit of a word and is high for the first half of the word.
- R6: The data and mode present at a rising edge of ret_clk_i are transmitted in the word that begins at the first word boundary strictly after that edge.
- R7: The mode pins are sampled together with the data. A format change alters word length and bit selection only from the word boundary at which the word captured with it starts.
- R8: With ext_clk_sel_ni low, all bit timing comes from ext_clk_i, and int_clk_i has no effect.
- R9: While rst_ni is low, out_en_o and ser_o are 0 and sub_clk_o is 1, independent of any clock.
- R10: After rst_ni rises, ser_o stays 0 until a word captured after reset has been loaded. The first word period after release is a 4-bit all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk_i | input | 1 | Internally generated bit clock |
| ext_clk_i | input | 1 | External bit clock |
| ext_clk_sel_ni | input | 1 | Low selects ext_clk_i as the bit clock |
| ret_clk_i | input | 1 | Word-rate retiming clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 1 | Low: high line rate; high: low line rate |
| nib_sel_i | input | 1 | At low rate: high nibble, low byte |
| data_i | input | WORD_W | Parallel word, bit WORD_W-1 sent first |
| ser_o | output | 1 | Serial line data |
| sub_clk_o | output | 1 | Word-rate clock, rises at each word start |
| out_en_o | output | 1 | Line output enable, low in reset |

## Verification
The load of a new word into the shift register and the latching of its format fall on the same bit-clock edge as the end of the previous word, whose length is set by the older format. The bench provokes this by changing format on back-to-back words, both between byte and nibble and in a mixed random run. It judges each word by its own length in bit clocks and its own bit pattern, so that a load taken one edge early or late, or a format applied to the wrong word, shows up as a length or data miscompare. A second coincidence is the capture of a retimed word on the same edge where the previous retimed word is loaded. The bench forces it by returning the sub-rate clock as the retiming clock.

// File: rtl/par2ser_tx_pkg.sv
package par2ser_tx_pkg;
  typedef enum logic {
    FMT_BYTE = 1'b0,
    FMT_NIB  = 1'b1
  } fmt_e;
endpackage

// File: rtl/par2ser_clk_sel.sv
module par2ser_clk_sel (
  input  logic int_clk_i,
  input  logic ext_clk_i,
  input  logic ext_sel_ni,
  output logic bit_clk_o
);
  assign bit_clk_o = ext_sel_ni ? int_clk_i : ext_clk_i;
endmodule

// File: rtl/par2ser_retime.sv
module par2ser_retime
  import par2ser_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              ret_clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              rate_sel_i,
  input  logic              nib_sel_i,
  output logic [WORD_W-1:0] data_o,
  output fmt_e              fmt_o,
  output logic              vld_o
);
  fmt_e fmt_d;

  // nibble only at low rate
  assign fmt_d = (rate_sel_i && nib_sel_i) ? FMT_NIB : FMT_BYTE;

  always_ff @(posedge ret_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      fmt_o  <= FMT_NIB;
      vld_o  <= 1'b0;
    end else begin
      data_o <= data_i;
      fmt_o  <= fmt_d;
      vld_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/par2ser_divider.sv
module par2ser_divider
  import par2ser_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  fmt_e fmt_i,
  output logic load_o,
  output logic sub_clk_o,
  output logic oe_o
);
  localparam int unsigned NIB_W = WORD_W / 2;
  localparam int unsigned CW    = $clog2(WORD_W);

  logic [CW-1:0] cnt_q, cnt_d, last_cnt, half_cnt;
  logic          sub_q, oe_q;

  always_comb begin
    last_cnt = (fmt_i == FMT_NIB) ? CW'(NIB_W - 1) : CW'(WORD_W - 1);
    half_cnt = (fmt_i == FMT_NIB) ? CW'(NIB_W / 2) : CW'(WORD_W / 2);
    load_o   = (cnt_q == last_cnt);
    cnt_d    = load_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sub_q <= (cnt_d < half_cnt);
      oe_q  <= 1'b1;
    end
  end

  assign sub_clk_o = sub_q;
  assign oe_o      = oe_q;
endmodule

// File: rtl/par2ser_shifter.sv
module par2ser_shifter
  import par2ser_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  fmt_e              fmt_i,
  input  logic              vld_i,
  input  logic              oe_i,
  output fmt_e              fmt_o,
  output logic              ser_o
);
  localparam int unsigned NIB_W = WORD_W / 2;

  logic [WORD_W-1:0] shift_q, load_val;
  fmt_e              fmt_q;
  logic              vld_q;

  // nibble words left-justified so the MSB goes out first in both formats
  assign load_val = (fmt_i == FMT_NIB) ?
                    {data_i[WORD_W-1 -: NIB_W], {(WORD_W-NIB_W){1'b0}}} : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      fmt_q   <= FMT_NIB;
      vld_q   <= 1'b0;
    end else if (load_i) begin
      shift_q <= load_val;
      fmt_q   <= fmt_i;
      vld_q   <= vld_q | vld_i;
    end else begin
      shift_q <= {shift_q[WORD_W-2:0], 1'b0};
    end
  end

  assign fmt_o = fmt_q;
  assign ser_o = oe_i & vld_q & shift_q[WORD_W-1];
endmodule

// File: rtl/par2ser_tx.sv
module par2ser_tx
  import par2ser_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              int_clk_i,
  input  logic              ext_clk_i,
  input  logic              ext_clk_sel_ni,
  input  logic              ret_clk_i,
  input  logic              rst_ni,
  input  logic              rate_sel_i,
  input  logic              nib_sel_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ser_o,
  output logic              sub_clk_o,
  output logic              out_en_o
);
  logic              bit_clk;
  logic [WORD_W-1:0] ret_data;
  fmt_e              ret_fmt;
  logic              ret_vld;
  fmt_e              cur_fmt;
  logic              load;

  par2ser_clk_sel u_clk_sel (
    .int_clk_i  (int_clk_i),
    .ext_clk_i  (ext_clk_i),
    .ext_sel_ni (ext_clk_sel_ni),
    .bit_clk_o  (bit_clk)
  );

  par2ser_retime #(.WORD_W(WORD_W)) u_retime (
    .ret_clk_i  (ret_clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .rate_sel_i (rate_sel_i),
    .nib_sel_i  (nib_sel_i),
    .data_o     (ret_data),
    .fmt_o      (ret_fmt),
    .vld_o      (ret_vld)
  );

  par2ser_divider #(.WORD_W(WORD_W)) u_divider (
    .clk_i     (bit_clk),
    .rst_ni    (rst_ni),
    .fmt_i     (cur_fmt),
    .load_o    (load),
    .sub_clk_o (sub_clk_o),
    .oe_o      (out_en_o)
  );

  par2ser_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i  (bit_clk),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (ret_data),
    .fmt_i  (ret_fmt),
    .vld_i  (ret_vld),
    .oe_i   (out_en_o),
    .fmt_o  (cur_fmt),
    .ser_o  (ser_o)
  );
endmodule

// File: rtl/par2ser_tx_chk.sv
module par2ser_tx_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sub_clk_i,
  input logic ser_i,
  input logic out_en_i,
  input logic fmt_i
);
  localparam int unsigned PW = $clog2(WORD_W) + 2;

  logic          sub_prev_q, seen_q, rise_det;
  logic [PW-1:0] pos_q;

  assign rise_det = sub_clk_i && !sub_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_prev_q <= 1'b1;
      seen_q     <= 1'b0;
      pos_q      <= '0;
    end else begin
      sub_prev_q <= sub_clk_i;
      if (rise_det) begin
        seen_q <= 1'b1;
        pos_q  <= PW'(1);
      end else if (pos_q != '1) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  p_rst_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_en_i && !ser_i && sub_clk_i));

  p_word_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_det && seen_q) |-> (pos_q == PW'(WORD_W) || pos_q == PW'(WORD_W/2)));

  p_fmt_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fmt_i) |-> (sub_clk_i && !$past(sub_clk_i)));

  p_oe_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i |=> out_en_i);

  p_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !rise_det) |-> !ser_i);
endmodule

bind par2ser_tx par2ser_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (bit_clk),
  .rst_ni    (rst_ni),
  .sub_clk_i (sub_clk_o),
  .ser_i     (ser_o),
  .out_en_i  (out_en_o),
  .fmt_i     (cur_fmt)
);

// File: tb/par2ser_tx_tb.sv
`timescale 1ns/1ps
module par2ser_tx_tb;
  logic       int_clk = 1'b0, ext_clk = 1'b0;
  logic       int_run = 1'b1, ext_run = 1'b0;
  logic       rst_n = 1'b1, ext_sel_n = 1'b1;
  logic       rate_sel = 1'b1, nib_sel = 1'b1;
  logic [7:0] data = 8'h00;
  wire        ser, sub_clk, out_en;
  wire        any_clk = int_clk | ext_clk;
  int         checks = 0, fails = 0;
  bit         done = 1'b0, mon_en = 1'b0;

  always #2 int_clk = int_run ? ~int_clk : 1'b0;
  always #2 ext_clk = ext_run ? ~ext_clk : 1'b0;

  par2ser_tx u_dut (
    .int_clk_i      (int_clk),
    .ext_clk_i      (ext_clk),
    .ext_clk_sel_ni (ext_sel_n),
    .ret_clk_i      (sub_clk),
    .rst_ni         (rst_n),
    .rate_sel_i     (rate_sel),
    .nib_sel_i      (nib_sel),
    .data_i         (data),
    .ser_o          (ser),
    .sub_clk_o      (sub_clk),
    .out_en_o       (out_en)
  );

  typedef struct {
    logic [7:0] bits;
    int         width;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic push_zero(input string tag);
    exp_t e;
    e.bits = 8'h00; e.width = 4; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // driver: present next word after a sub clock fall, log expected frame
  task automatic send(input logic [7:0] d, input logic r, input logic n, input string tag);
    exp_t e;
    @(negedge sub_clk);
    #1;
    data = d; rate_sel = r; nib_sel = n;
    e.width = (r && n) ? 4 : 8;
    e.bits  = (r && n) ? {4'h0, d[7:4]} : d;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (2) @(posedge sub_clk);
    #3;
  endtask

  // monitor: frame starts where sub clock rose, bits sampled mid-period
  exp_t       cur;
  bit         cur_v = 1'b0;
  int         nb = 0;
  logic [7:0] sh = 8'h00;
  logic       prev_sub = 1'b1;

  always @(negedge any_clk) begin
    if (!rst_n || !mon_en) begin
      cur_v    = 1'b0;
      nb       = 0;
      prev_sub = sub_clk;
    end else begin
      if (sub_clk && !prev_sub) begin
        if (cur_v) begin
          check(nb == cur.width, {cur.tag, " R5"}, "word length", nb, cur.width);
          check(sh == cur.bits, {cur.tag, " R6"}, "word bits", {24'h0, sh}, {24'h0, cur.bits});
        end
        cur_v = 1'b0;
        if (exp_q.size() > 0) begin
          cur   = exp_q.pop_front();
          cur_v = 1'b1;
          nb    = 0;
          sh    = 8'h00;
        end
      end
      if (cur_v) begin
        sh = {sh[6:0], ser};
        nb++;
      end
      prev_sub = sub_clk;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #6;
    check(out_en == 1'b0, "R9", "out_en in reset", out_en, 0);
    check(ser == 1'b0, "R9", "ser in reset", ser, 0);
    check(sub_clk == 1'b1, "R9", "sub_clk in reset", sub_clk, 1);
    @(negedge int_clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    push_zero("R10");
    send(8'hA5, 1'b0, 1'b0, "R1");
    send(8'h3C, 1'b0, 1'b0, "R1");
    send(8'h96, 1'b0, 1'b1, "R4");
    send(8'h69, 1'b0, 1'b1, "R4");
    send(8'h5A, 1'b1, 1'b0, "R2");
    send(8'hC7, 1'b1, 1'b1, "R3");
    send(8'h38, 1'b1, 1'b1, "R3");
    send(8'h81, 1'b1, 1'b0, "R7");
    send(8'hE0, 1'b1, 1'b1, "R7");
    send(8'hFF, 1'b0, 1'b0, "R7");
    send(8'h00, 1'b1, 1'b1, "R7");
    send(8'hF0, 1'b1, 1'b1, "R3");
    send(8'h0F, 1'b1, 1'b1, "R3");
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      logic       r, n;
      d = 8'($urandom);
      r = 1'($urandom);
      n = 1'($urandom);
      send(d, r, n, "R7");
    end
    drain();

    // asynchronous reset while sub clock is low
    @(negedge sub_clk);
    #1 rst_n = 1'b0;
    #1;
    check(sub_clk == 1'b1, "R9", "sub_clk async clear", sub_clk, 1);
    check(out_en == 1'b0, "R9", "out_en async clear", out_en, 0);
    check(ser == 1'b0, "R9", "ser async clear", ser, 0);

    // switch to external bit clock under reset, internal clock stopped
    int_run   = 1'b0;
    ext_sel_n = 1'b0;
    ext_run   = 1'b1;
    #20;
    @(negedge ext_clk);
    rst_n = 1'b1;
    push_zero("R10");
    send(8'hB4, 1'b0, 1'b0, "R8");
    send(8'hD2, 1'b1, 1'b1, "R8");
    send(8'h4E, 1'b1, 1'b0, "R8");
    send(8'h71, 1'b1, 1'b1, "R8");
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule